// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Core

This block is a compact processor built around one accumulator register and an internal word-addressed memory that holds both program and data. Every instruction is one 16-bit word: a 4-bit operation code in bits 15:12 and a 12-bit memory address in bits 11:0. The core fetches a word, splits it into operation and address fields, and then performs a direct or memory-indirect load or store, an add or subtract against memory, an unconditional jump, a jump conditioned on the accumulator being zero or negative, or a halt.

Internally the datapath holds a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. A one-hot step sequencer with ten steps drives the control decode, and each instruction returns the sequencer to its first step when it ends. Indirect instructions spend two extra steps on a second memory access. While the core is held in reset, an external write port fills the memory with a program and its data. Once reset is released the core runs from address 0 until it halts, with the accumulator and a halted flag visible at its outputs.

Top module: `acc_core`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, acc_out is 0 and halted is 0; execution always starts by fetching address 0.
- R2: While reset is held, a write through the preload port (pre_we high) stores pre_data at pre_addr, and the running program later fetches and reads exactly those words.
- R3: Opcode 1 loads the accumulator from word X; opcode 3 writes the accumulator to word X, and a later load of X returns the stored value.
- R4: Opcode 2 reads word X, uses its low 12 bits as an address and loads the accumulator from that address; opcode 4 writes the accumulator to the address held in the low 12 bits of word X.
- R5: Opcode 5 adds word X to the accumulator and opcode 6 subtracts word X from it, both wrapping modulo 2^16 with no flag.
- R6: Opcode 7 always sets the program counter to X.
- R7: Opcode 8 sets the program counter to X only when the accumulator equals 0; otherwise execution continues with the next word.
- R8: Opcode 9 sets the program counter to X only when accumulator bit 15 is 1; otherwise execution continues with the next word.
- R9: Opcode 15 raises halted; from then on halted stays 1 and the accumulator and program counter hold until reset is asserted, which clears halted.
- R10: Opcodes 0 and 10 to 14 change nothing except that execution moves to the next word.
- R11: Instructions take, counted from the start of their fetch: 4 cycles for opcodes 7, 8, 9, 15 and no-ops; 5 for opcode 3; 6 for opcodes 1, 5 and 6; 7 for opcode 4; 8 for opcode 2. Exactly one step is active at a time and the accumulator changes only in the last step of a load, add or subtract.
- R12: The program counter advances by one during every instruction fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pre_we | input | 1 | Preload write strobe, honoured only while the core is in reset |
| pre_addr | input | 12 | Preload word address |
| pre_data | input | 16 | Preload word value |
| halted | output | 1 | High once a halt instruction has executed |
| acc_out | output | 16 | Current accumulator value |

## Verification
One program is loaded that walks through every operation, with data chosen so that each accumulator result differs from the one before; the bench predicts that chain of values together with the cycle gap between successive changes. Subtracting past zero and adding past 0x7FFF separate correct wrap-around from saturation, and placing each conditional jump once where it must be taken and once where it must fall through to a halt trap separates a correct condition test from an inverted or always-taken one. The indirect load and store are confirmed by reading the pointed-to word back with a direct load, and the cycle gaps show whether each instruction class uses the right number of steps. The program is then run a second time after a reset during halt to show that the halt clears and the program counter restarts at 0.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW    = 4;
  localparam int NSTEPS = 10;

  localparam logic [OPW-1:0] OP_LDA = 4'h1;
  localparam logic [OPW-1:0] OP_LDI = 4'h2;
  localparam logic [OPW-1:0] OP_STA = 4'h3;
  localparam logic [OPW-1:0] OP_STI = 4'h4;
  localparam logic [OPW-1:0] OP_ADD = 4'h5;
  localparam logic [OPW-1:0] OP_SUB = 4'h6;
  localparam logic [OPW-1:0] OP_JMP = 4'h7;
  localparam logic [OPW-1:0] OP_JMZ = 4'h8;
  localparam logic [OPW-1:0] OP_JMN = 4'h9;
  localparam logic [OPW-1:0] OP_HLT = 4'hF;

  typedef enum logic [1:0] {MAR_PC, MAR_IR, MAR_MBR} mar_src_t;
  typedef enum logic [1:0] {AC_MBR, AC_SUM, AC_DIFF} ac_src_t;

  typedef struct packed {
    logic     mar_ld;
    mar_src_t mar_sel;
    logic     mbr_ld;
    logic     ir_ld;
    logic     pc_inc;
    logic     pc_ld;
    logic     ac_ld;
    ac_src_t  ac_sel;
    logic     mem_we;
    logic     halt_set;
    logic     step_clr;
  } ctrl_t;
endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/acc_step.sv
module acc_step #(
  parameter int NS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          clr,
  output logic [NS-1:0] step
);
  localparam int CW = $clog2(NS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                          cnt_d = '0;
    else if (adv && cnt_q == CW'(NS-1)) cnt_d = '0;
    else if (adv)                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar i = 0; i < NS; i++) begin : g_dec
    assign step[i] = (cnt_q == CW'(i));
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic [NSTEPS-1:0] step,
  input  logic [OPW-1:0]    op,
  input  logic              ac_zero,
  input  logic              ac_neg,
  input  logic              halted,
  output ctrl_t             c
);
  logic is_direct_rd, is_indirect;

  assign is_direct_rd = (op == OP_LDA) || (op == OP_ADD) || (op == OP_SUB);
  assign is_indirect  = (op == OP_LDI) || (op == OP_STI);

  always_comb begin
    c = '0;
    if (!halted) begin
      if (step[0]) begin
        c.mar_ld = 1'b1; c.mar_sel = MAR_PC;
      end else if (step[1]) begin
        c.mbr_ld = 1'b1; c.pc_inc = 1'b1;
      end else if (step[2]) begin
        c.ir_ld = 1'b1;
      end else if (step[3]) begin
        if (op == OP_HLT) begin
          c.halt_set = 1'b1; c.step_clr = 1'b1;
        end else if (op == OP_JMP) begin
          c.pc_ld = 1'b1; c.step_clr = 1'b1;
        end else if (op == OP_JMZ) begin
          c.pc_ld = ac_zero; c.step_clr = 1'b1;
        end else if (op == OP_JMN) begin
          c.pc_ld = ac_neg; c.step_clr = 1'b1;
        end else if (is_direct_rd || is_indirect || op == OP_STA) begin
          c.mar_ld = 1'b1; c.mar_sel = MAR_IR;
        end else begin
          c.step_clr = 1'b1;
        end
      end else if (step[4]) begin
        if (op == OP_STA) begin
          c.mem_we = 1'b1; c.step_clr = 1'b1;
        end else begin
          c.mbr_ld = 1'b1;
        end
      end else if (step[5]) begin
        if (is_indirect) begin
          c.mar_ld = 1'b1; c.mar_sel = MAR_MBR;
        end else begin
          c.ac_ld    = 1'b1;
          c.step_clr = 1'b1;
          c.ac_sel   = (op == OP_ADD) ? AC_SUM : (op == OP_SUB) ? AC_DIFF : AC_MBR;
        end
      end else if (step[6]) begin
        if (op == OP_STI) begin
          c.mem_we = 1'b1; c.step_clr = 1'b1;
        end else begin
          c.mbr_ld = 1'b1;
        end
      end else if (step[7]) begin
        c.ac_ld = 1'b1; c.ac_sel = AC_MBR; c.step_clr = 1'b1;
      end else if (|step[NSTEPS-1:8]) begin
        c.step_clr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = DW - OPW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  output logic          halted,
  output logic [DW-1:0] acc_out
);
  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic [AW-1:0]     pc_q, pc_d, mar_q, mar_d;
  logic [DW-1:0]     mbr_q, ir_q, ac_q, ac_d, mem_rdata;
  logic              halted_q, halted_d;
  logic [NSTEPS-1:0] step_oh;
  logic [OPW-1:0]    ir_op;
  logic [AW-1:0]     ir_addr;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DW-1:0]     mem_wdata;
  ctrl_t             c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign ir_op   = ir_q[DW-1 -: OPW];
  assign ir_addr = ir_q[AW-1:0];

  acc_step #(.NS(NSTEPS)) u_step (
    .clk(clk), .rst_n(rst_sync_n), .adv(!halted_q), .clr(c.step_clr), .step(step_oh)
  );

  acc_ctrl u_ctrl (
    .step(step_oh), .op(ir_op), .ac_zero(ac_q == '0), .ac_neg(ac_q[DW-1]),
    .halted(halted_q), .c(c)
  );

  assign mem_we    = rst_sync_n ? c.mem_we : pre_we;
  assign mem_waddr = rst_sync_n ? mar_q    : pre_addr;
  assign mem_wdata = rst_sync_n ? ac_q     : pre_data;

  acc_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mar_q), .rdata(mem_rdata)
  );

  always_comb begin
    pc_d = pc_q;
    if (c.pc_ld)       pc_d = ir_addr;
    else if (c.pc_inc) pc_d = pc_q + 1'b1;

    case (c.mar_sel)
      MAR_IR:  mar_d = ir_addr;
      MAR_MBR: mar_d = mbr_q[AW-1:0];
      default: mar_d = pc_q;
    endcase

    case (c.ac_sel)
      AC_SUM:  ac_d = ac_q + mbr_q;
      AC_DIFF: ac_d = ac_q - mbr_q;
      default: ac_d = mbr_q;
    endcase

    halted_d = halted_q | c.halt_set;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q     <= '0;
      mar_q    <= '0;
      mbr_q    <= '0;
      ir_q     <= '0;
      ac_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      if (c.pc_ld || c.pc_inc) pc_q  <= pc_d;
      if (c.mar_ld)            mar_q <= mar_d;
      if (c.mbr_ld)            mbr_q <= mem_rdata;
      if (c.ir_ld)             ir_q  <= mbr_q;
      if (c.ac_ld)             ac_q  <= ac_d;
      if (c.halt_set)          halted_q <= halted_d;
    end
  end

  assign halted  = halted_q;
  assign acc_out = ac_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSTEPS-1:0] step,
  input logic              halted,
  input logic [DW-1:0]     acc,
  input logic [AW-1:0]     pc,
  input logic [OPW-1:0]    op,
  input logic [AW-1:0]     ir_addr,
  input logic              mem_we
);
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step) == 1); // R11

  AST_AC_EARLY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step[0] || step[1] || step[2] || step[3] || step[4] || step[6]) |=> $stable(acc)); // R11

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R9

  AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(acc) && $stable(pc))); // R9

  AST_FETCH_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step[1] && !halted) |=> pc == AW'($past(pc) + 1'b1)); // R12

  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (step[3] && !halted && op == OP_JMP) |=> pc == $past(ir_addr)); // R6

  AST_STORE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(step[0] || step[1] || step[2] || step[3])); // R3
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .step(step_oh), .halted(halted_q), .acc(ac_q),
  .pc(pc_q), .op(ir_op), .ir_addr(ir_addr), .mem_we(c.mem_we)
);

// File: tb/sim_acc_core.sv
`timescale 1ns/1ps
module sim_acc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_we;
  logic [11:0] pre_addr;
  logic [15:0] pre_data;
  logic        halted;
  logic [15:0] acc_out;

  typedef struct {
    logic [15:0] val;
    int          gap;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  int          last_cyc = 0;
  logic [15:0] prev_acc = '0;
  bit          mon_en = 1'b0;

  always #4 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .halted(halted), .acc_out(acc_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] v, input int g, input string t);
    exp_t e;
    e.val = v; e.gap = g; e.tag = t;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic load_program();
    wr(0, 16'h1064);  wr(1, 16'h5065);  wr(2, 16'h6067);  wr(3, 16'h9005);
    wr(4, 16'hF000);  wr(5, 16'h3068);  wr(6, 16'h2069);  wr(7, 16'h406B);
    wr(8, 16'h1064);  wr(9, 16'h106C);  wr(10, 16'h1068); wr(11, 16'h6068);
    wr(12, 16'h800E); wr(13, 16'hF000); wr(14, 16'h506D); wr(15, 16'h801E);
    wr(16, 16'h901E); wr(17, 16'hA000); wr(18, 16'h506E); wr(19, 16'h9015);
    wr(20, 16'hF000); wr(21, 16'h7017); wr(22, 16'hF000); wr(23, 16'h106F);
    wr(24, 16'hF000); wr(30, 16'hF000);
    wr(100, 16'h0005); wr(101, 16'h0003); wr(103, 16'h000A); wr(104, 16'h0000);
    wr(105, 16'h006A); wr(106, 16'h1234); wr(107, 16'h006C); wr(108, 16'h0000);
    wr(109, 16'h7FFF); wr(110, 16'h0001); wr(111, 16'h0042);
  endtask

  // Expected accumulator chain and the cycle gap between changes
  task automatic push_expected();
    push(16'h0005, 0,  "R2/R12 preload fetched, LDA");
    push(16'h0008, 6,  "R5 ADD");
    push(16'hFFFE, 6,  "R5 SUB wrap");
    push(16'h1234, 17, "R4 LDI after R8 taken");
    push(16'h0005, 13, "R3 LDA");
    push(16'h1234, 6,  "R4 STI readback");
    push(16'hFFFE, 6,  "R3 STA readback");
    push(16'h0000, 6,  "R5 SUB to zero");
    push(16'h7FFF, 10, "R7 JMZ taken");
    push(16'h8000, 18, "R10 no-op, R7/R8 not taken, R5 wrap");
    push(16'h0042, 14, "R8/R6 JMN and JMP taken");
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_en && acc_out !== prev_acc) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11 unexpected accumulator change", acc_out, prev_acc);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(acc_out === e.val, e.tag, acc_out, e.val);
        if (e.gap != 0)
          check((cyc - last_cyc) == e.gap, {"R11 cycle gap before ", e.tag}, cyc - last_cyc, e.gap);
      end
      prev_acc = acc_out;
      last_cyc = cyc;
    end
  end

  task automatic run_to_halt();
    int waited;
    waited = 0;
    while (!halted && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    repeat (40) @(negedge clk);
    check(halted === 1'b1, "R9 halted raised and held", halted, 1);
    check(acc_out === 16'h0042, "R9 accumulator frozen after halt", acc_out, 16'h0042);
    check(sb.size() == 0, "R6 all expected results produced", sb.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog expired actual=running expected=halt");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    repeat (3) @(negedge clk);
    load_program();
    check(acc_out === 16'h0000, "R1 accumulator in reset", acc_out, 0);
    check(halted === 1'b0, "R1 halted in reset", halted, 0);

    push_expected();
    prev_acc = '0; last_cyc = cyc; mon_en = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check(acc_out === 16'h0000, "R1 accumulator after release", acc_out, 0);
    run_to_halt();

    @(negedge clk);
    mon_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(halted === 1'b0, "R9 reset clears halt", halted, 0);
    check(acc_out === 16'h0000, "R1 reset clears accumulator", acc_out, 0);

    push_expected();
    prev_acc = '0; last_cyc = cyc; mon_en = 1'b1;
    rst_n = 1'b1;
    run_to_halt();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule